// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a 4 KB window of 32-bit control and status words. It sits on a simple word-addressed bus that has a valid strobe, a write enable, a 12-bit byte address and 32-bit data. A write-lock guards the control words. Software releases the lock by writing a 16-bit magic value to the unlock word. It engages the lock again with a different magic value written to the lock word. A status word reports the current lock state. While the bank is locked, every write is dropped except writes to the lock and unlock words.

Inside the implemented ranges a few words are read-only status and hold their reset value. One word is a hole that reads as zero. Any offset outside the ranges reads as zero and ignores writes. No bus error is ever signalled. An unlocked write to the software reset word with bit 0 set stores the value and raises a one-cycle system reset request. The block comes out of reset locked.

The implemented word ranges are 0x100–0x1D8, 0x200–0x25C, 0x600–0x620, 0x700–0x7D4 and 0xB00–0xB2C. The two low address bits are ignored.

Top module: `keyed_ctrl_bank`

## Requirements
- R1: After reset the words at 0x100, 0x104 and 0x108 read 0x0001A008. Word 0x10C reads 0x0000003F and word 0x250 reads 0x00000040. Every other implemented word reads zero.
- R2: A write to offset 0x004 engages the lock only when write data bits [15:0] equal 0x767B. The upper bits are ignored. Any other value leaves the lock state unchanged.
- R3: A write to offset 0x008 releases the lock only when write data bits [15:0] equal 0xDF0D. The upper bits are ignored. Any other value leaves the lock state unchanged.
- R4: Offset 0x00C reads bit 0 = 1 when the bank is locked and 0 when it is unlocked, with bits [31:1] zero. Writes to 0x00C have no effect.
- R5: Reads of offsets 0x004 and 0x008 return zero.
- R6: While the bank is locked, writes to every offset other than 0x004 and 0x008 change no stored word and raise no reset request. The bank is locked after reset.
- R7: While the bank is unlocked, a write to a writable implemented word stores all 32 bits, and a later read returns them.
- R8: Words 0x10C, 0x250, 0xB20 and 0xB2C are read-only. They keep their reset values (0x3F, 0x40, 0 and 0) whatever is written to them.
- R9: Offset 0x604 and every offset outside the implemented ranges read zero and ignore writes.
- R10: An unlocked write to offset 0x200 with data bit 0 set drives sys_reset_req high for exactly the one cycle after the write. No other write raises it.
- R11: Read data appears on bus_rdata one cycle after the read is accepted. It then holds until the next read, and writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Transaction strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench sweeps every one of the 1024 word offsets three times: once at reset, once after writing an address-derived pattern while locked, and once after writing it while unlocked. Comparing the two written passes separates the lock gating from ordinary storage, and the per-offset expectations separate writable words from read-only words, holes and unmapped space. Key writes are tried with near-miss low halves and with matching low halves under arbitrary upper bits, which shows that only bits [15:0] are compared. Reset-word writes with bit 0 clear, with bit 0 set, and with the bank locked show whether the pulse is gated correctly and lasts a single cycle.

// File: rtl/keyed_ctrl_bank.sv
module keyed_ctrl_bank #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [15:0] LOCK_KEY = 16'h767B,
  parameter logic [15:0] UNLOCK_KEY = 16'hDF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_reset_req
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int WORDS = 1 << IDX_W;
  localparam logic [IDX_W-1:0] W_LOCK   = IDX_W'(1);
  localparam logic [IDX_W-1:0] W_UNLOCK = IDX_W'(2);
  localparam logic [IDX_W-1:0] W_STATUS = IDX_W'(3);
  localparam logic [IDX_W-1:0] W_SWRST  = IDX_W'(12'h200 >> 2);

  function automatic logic is_mapped(input logic [IDX_W-1:0] w);
    return (w >= IDX_W'(12'h100 >> 2) && w <= IDX_W'(12'h1D8 >> 2)) ||
           (w >= IDX_W'(12'h200 >> 2) && w <= IDX_W'(12'h25C >> 2)) ||
           (w >= IDX_W'(12'h600 >> 2) && w <= IDX_W'(12'h620 >> 2) && w != IDX_W'(12'h604 >> 2)) ||
           (w >= IDX_W'(12'h700 >> 2) && w <= IDX_W'(12'h7D4 >> 2)) ||
           (w >= IDX_W'(12'hB00 >> 2) && w <= IDX_W'(12'hB2C >> 2));
  endfunction

  function automatic logic is_ro(input logic [IDX_W-1:0] w);
    return w == IDX_W'(12'h10C >> 2) || w == IDX_W'(12'h250 >> 2) ||
           w == IDX_W'(12'hB20 >> 2) || w == IDX_W'(12'hB2C >> 2);
  endfunction

  function automatic logic [DATA_W-1:0] init_val(input logic [IDX_W-1:0] w);
    if (w >= IDX_W'(12'h100 >> 2) && w <= IDX_W'(12'h108 >> 2)) return DATA_W'(32'h0001_A008);
    if (w == IDX_W'(12'h10C >> 2)) return DATA_W'(32'h0000_003F);
    if (w == IDX_W'(12'h250 >> 2)) return DATA_W'(32'h0000_0040);
    return '0;
  endfunction

  logic [DATA_W-1:0] regs [WORDS];
  logic              locked;
  logic [IDX_W-1:0]  widx;
  logic              wr, rd, can_store;
  logic [DATA_W-1:0] rd_word;
  logic [1:0]        unused_lsb;

  assign widx       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = bus_addr[1:0];
  assign wr         = bus_valid & bus_write;
  assign rd         = bus_valid & ~bus_write;
  assign can_store  = wr & ~locked & is_mapped(widx) & ~is_ro(widx);

  always_comb begin
    if (widx == W_STATUS)       rd_word = DATA_W'(locked);
    else if (is_mapped(widx))   rd_word = regs[widx];
    else                        rd_word = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
    end else if (wr && widx == W_LOCK && bus_wdata[15:0] == LOCK_KEY) begin
      locked <= 1'b1;
    end else if (wr && widx == W_UNLOCK && bus_wdata[15:0] == UNLOCK_KEY) begin
      locked <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) regs[i] <= init_val(IDX_W'(i));
    end else if (can_store) begin
      regs[widx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata     <= '0;
      sys_reset_req <= 1'b0;
    end else begin
      if (rd) bus_rdata <= rd_word;
      sys_reset_req <= can_store && widx == W_SWRST && bus_wdata[0];
    end
  end
endmodule

// File: rtl/keyed_ctrl_bank_chk.sv
module keyed_ctrl_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        sys_reset_req,
  input logic        locked
);
  logic       rd, wr;
  logic [9:0] w;
  assign rd = bus_valid && !bus_write;
  assign wr = bus_valid && bus_write;
  assign w  = bus_addr[11:2];

  AST_LOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(wr && w == 10'd1 && bus_wdata[15:0] == 16'h767B)); // R2
  AST_UNLOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(wr && w == 10'd2 && bus_wdata[15:0] == 16'hDF0D)); // R3
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && w == 10'd3) |=> bus_rdata == {31'b0, $past(locked)}); // R4
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (w == 10'd1 || w == 10'd2)) |=> bus_rdata == 32'b0); // R5
  AST_LOCKED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr && w == 10'h080) |=> !sys_reset_req); // R6
  AST_RO_PLL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && w == 10'h043) |=> bus_rdata == 32'h3F); // R8
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && w == 10'h181) |=> bus_rdata == 32'b0); // R9
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(wr && w == 10'h080 && bus_wdata[0] && !locked)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata)); // R11
endmodule

bind keyed_ctrl_bank keyed_ctrl_bank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .sys_reset_req(sys_reset_req), .locked(locked)
);

// File: tb/keyed_ctrl_bank_tb_top.sv
`timescale 1ns/1ps
module keyed_ctrl_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic lk;
  logic [31:0] model [1024];

  always #10 clk = ~clk;

  keyed_ctrl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_reset_req(sys_reset_req)
  );

  function automatic bit mapped(input int w);
    int b = w * 4;
    return (b >= 'h100 && b <= 'h1D8) || (b >= 'h200 && b <= 'h25C) ||
           (b >= 'h600 && b <= 'h620 && b != 'h604) ||
           (b >= 'h700 && b <= 'h7D4) || (b >= 'hB00 && b <= 'hB2C);
  endfunction

  function automatic bit ro(input int w);
    int b = w * 4;
    return b == 'h10C || b == 'h250 || b == 'hB20 || b == 'hB2C;
  endfunction

  function automatic logic [31:0] rst_val(input int w);
    int b = w * 4;
    if (b >= 'h100 && b <= 'h108) return 32'h0001_A008;
    if (b == 'h10C) return 32'h3F;
    if (b == 'h250) return 32'h40;
    return 32'h0;
  endfunction

  function automatic logic [31:0] pat(input int w, input logic [31:0] salt);
    return (w * 32'h9E37_79B1) ^ salt;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int w, input logic [31:0] d, input string req);
    logic exp_pulse;
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = {w[9:0], 2'b00}; bus_wdata = d;
    exp_pulse = !lk && w == 'h80 && d[0];
    if (!lk && mapped(w) && !ro(w)) model[w] = d;
    if (w == 1 && d[15:0] == 16'h767B) lk = 1;
    else if (w == 2 && d[15:0] == 16'hDF0D) lk = 0;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    check({31'b0, sys_reset_req}, {31'b0, exp_pulse}, req);
  endtask

  task automatic do_read(input int w, input string req);
    logic [31:0] exp;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = {w[9:0], 2'b00};
    exp = (w == 3) ? {31'b0, lk} : model[w];
    @(negedge clk);
    bus_valid = 0;
    check(bus_rdata, exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = mapped(i) ? rst_val(i) : 32'h0;
    lk = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(bus_rdata, 32'h0, "R1 rdata reset");
    check({31'b0, sys_reset_req}, 32'h0, "R10 req reset");

    // R1 R4 R5 R9: reset sweep of every word
    for (int i = 0; i < 1024; i++) do_read(i, "R1 reset sweep");

    // R6: locked sweep, nothing may change
    for (int i = 0; i < 1024; i++)
      if (i != 1 && i != 2) do_write(i, pat(i, 32'hC3C3_0001), "R6 locked write");
    for (int i = 0; i < 1024; i++) do_read(i, "R6 locked sweep");

    // R3: near-miss unlock keys, then match with arbitrary upper half
    do_write(2, 32'h0000_DF0C, "R3 bad key");
    do_read(3, "R3 still locked");
    do_write(2, 32'hDF0D_0000, "R3 key in upper half");
    do_read(3, "R3 still locked");
    do_write(2, 32'hABCD_DF0D, "R3 good key");
    do_read(3, "R3 unlocked");
    check(bus_rdata, 32'h0, "R3 status reads unlocked");
    do_write(3, 32'hFFFF_FFFF, "R4 status write");
    do_read(3, "R4 status unchanged");

    // R7 R8 R9: unlocked sweep
    for (int i = 0; i < 1024; i++)
      if (i != 1 && i != 2) do_write(i, pat(i, 32'h5A5A_0000), "R10 no pulse in sweep");
    for (int i = 0; i < 1024; i++) do_read(i, "R7 R8 R9 unlocked sweep");
    do_read(1, "R5 lock word reads zero");
    do_read(2, "R5 unlock word reads zero");

    // R10: reset request pulse
    do_write('h80, 32'h0000_0002, "R10 bit0 clear");
    do_write('h80, 32'h1234_0001, "R10 bit0 set");
    @(negedge clk);
    check({31'b0, sys_reset_req}, 32'h0, "R10 single cycle");
    do_read('h80, "R10 value stored");

    // R2: lock keys
    do_write(1, 32'h0000_767A, "R2 bad key");
    do_read(3, "R2 still unlocked");
    do_write(1, 32'h1234_767B, "R2 good key");
    do_read(3, "R2 locked");
    check(bus_rdata, 32'h1, "R2 status reads locked");
    do_write('h80, 32'h0000_0001, "R6 R10 locked reset write");
    do_read('h80, "R6 reset word unchanged");
    do_write('h40, 32'hDEAD_BEEF, "R6 locked");
    do_read('h40, "R6 pll word unchanged");

    // R11: hold behaviour
    do_read('h43, "R8 pll status");
    repeat (3) @(negedge clk);
    check(bus_rdata, 32'h3F, "R11 hold idle");
    do_write('h50, 32'h0BAD_F00D, "R11 write between");
    check(bus_rdata, 32'h3F, "R11 hold after write");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule